// File: doc/BRIEF.md
# Clock-Gated Four-State Moore Controller

This block is a small Moore state machine with four states and a two-bit input symbol. Its state register is clocked through a gate. The gate closes in any cycle where the present state and the input symbol form the one combination that would leave the machine where it is. In every other cycle the register is clocked as usual. The outputs are decoded from the state alone, so a closed gate cannot disturb them.

The gate's enable comes from a detector that compares the input symbol with the current state. This detector is separate from the next-state logic. The enable is captured by a latch that is transparent while the clock is low and holds while the clock is high. The gated clock is the clock ANDed with the latched enable, so it cannot glitch when the symbol changes during the high phase. A synchronous active-high reset forces the gate open and returns the machine to state 0.

Top module: `gated_moore_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 2'b00 whatever `sym` is, and `gate_open` is high during that cycle.
- R2: With `rst` low, the state after a rising edge is (`sym` + 1) mod 4. The input symbol therefore names the state reached, minus one.
- R3: For the current state s, the self-loop symbol is (s − 1) mod 4. When that symbol is applied, the state does not change. Every other symbol moves the machine to a different state.
- R4: With `rst` low, `gate_open` is low at a rising edge exactly when `sym` equals the self-loop symbol of the current state. In all other cycles it is high.
- R5: `gate_open` changes only while `clk` is low. A change of `sym` during the high phase leaves it unchanged until the clock falls.
- R6: `zout` depends only on the state: 2'b00 gives 2'b00, 2'b01 gives 2'b01, 2'b10 gives 2'b01, and 2'b11 gives 2'b10.
- R7: Across any edge where the gate is closed, `state_q` and `zout` keep their values.
- R8: `state_q` and `zout` always equal those of an ungated machine that follows R1 to R3 and is clocked on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sym | input | 2 | Input symbol |
| state_q | output | 2 | Current state register |
| zout | output | 2 | Moore output decoded from the state |
| gate_open | output | 1 | Latched clock-gate enable |

## Verification
Random symbols are applied against an ungated model. They reach every state with each of the four symbols, so every self-loop pair and every move is covered. This separates correct gating from gating that holds the state too often or too rarely. Directed runs do three things: they apply each state's self-loop symbol repeatedly, they assert reset together with a self-loop symbol to show that reset overrides the gate, and they change the symbol during the high phase to show that the latch holds its enable. States 01 and 10 share an output value, so the zout checks also separate a decode by state from a decode by output class.

// File: rtl/gated_moore_fsm.sv
module gated_moore_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sym,
  output logic [1:0] state_q,
  output logic [1:0] zout,
  output logic       gate_open
);

  logic [1:0] nxt;
  logic       loop_hit;
  logic       en_raw;
  logic       en_lat;
  logic       gclk;

  always_comb begin
    if (rst) nxt = 2'b00;
    else     nxt = sym + 2'd1;
  end

  assign loop_hit = (sym == (state_q - 2'd1));
  assign en_raw   = rst | ~loop_hit;

  always_latch begin
    if (!clk) en_lat = en_raw;
  end

  assign gclk      = clk & en_lat;
  assign gate_open = en_lat;

  always_ff @(posedge gclk) state_q <= nxt;

  always_comb begin
    case (state_q)
      2'b00:   zout = 2'b00;
      2'b01:   zout = 2'b01;
      2'b10:   zout = 2'b01;
      default: zout = 2'b10;
    endcase
  end

endmodule

// File: rtl/gated_moore_fsm_chk.sv
module gated_moore_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sym,
  input logic [1:0] state_q,
  input logic [1:0] zout,
  input logic       gate_open
);

  AST_RST_INIT: assert property (@(posedge clk) rst |=> state_q == 2'b00); // R1
  AST_RST_GATE: assert property (@(posedge clk) rst |-> gate_open); // R1
  AST_NEXT_STATE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> state_q == $past(sym) + 2'd1); // R2
  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst) !gate_open |=> $stable(state_q)); // R3
  AST_OPEN_MOVES: assert property (@(posedge clk) disable iff (rst) gate_open |=> state_q != $past(state_q)); // R4
  AST_DECODE_TOP: assert property (@(posedge clk) disable iff (rst) state_q == 2'b11 |-> zout == 2'b10); // R6
  AST_DECODE_MID: assert property (@(posedge clk) disable iff (rst) (state_q == 2'b01 || state_q == 2'b10) |-> zout == 2'b01); // R6
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst) !gate_open |=> $stable(zout)); // R7

endmodule

bind gated_moore_fsm gated_moore_fsm_chk u_chk (
  .clk(clk), .rst(rst), .sym(sym), .state_q(state_q), .zout(zout), .gate_open(gate_open)
);

// File: tb/sim_gated_moore_fsm.sv
`timescale 1ns/1ps
module sim_gated_moore_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sym = 2'b00;
  logic [1:0] state_q;
  logic [1:0] zout;
  logic       gate_open;

  int vectors = 0;
  int misses  = 0;
  int closed  = 0;
  bit done    = 1'b0;
  logic [1:0] model = 2'b00;

  always #10 clk = ~clk;

  gated_moore_fsm u0 (
    .clk(clk), .rst(rst), .sym(sym),
    .state_q(state_q), .zout(zout), .gate_open(gate_open)
  );

  function automatic logic [1:0] step_f(logic [1:0] s, logic [1:0] d, logic r);
    if (r) return 2'b00;
    if (d == s - 2'd1) return s;
    return d + 2'd1;
  endfunction

  function automatic logic [1:0] dec_f(logic [1:0] s);
    case (s)
      2'b00: return 2'b00;
      2'b11: return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(logic r, logic [1:0] d);
    logic exp_gate;
    @(negedge clk);
    rst = r;
    sym = d;
    exp_gate = r || (d != model - 2'd1);
    @(posedge clk);
    model = step_f(model, d, r);
    #5;
    if (r) chk("R1 gate", {3'b0, gate_open}, 4'd1);
    else   chk("R4 gate", {3'b0, gate_open}, {3'b0, exp_gate});
    if (!exp_gate) closed++;
    chk(r ? "R1 state" : "R8 state", {2'b0, state_q}, {2'b0, model});
    chk("R6 zout", {2'b0, zout}, {2'b0, dec_f(model)});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    apply(1'b1, 2'b11);
    apply(1'b1, 2'b11);
    chk("R1 reset state", {2'b0, state_q}, 4'd0);

    for (int s = 0; s < 4; s++) begin
      apply(1'b0, 2'(s));
      for (int k = 0; k < 3; k++) begin
        logic [1:0] held;
        held = state_q;
        apply(1'b0, held - 2'd1);
        chk("R3 hold", {2'b0, state_q}, {2'b0, held});
        chk("R7 zout frozen", {2'b0, zout}, {2'b0, dec_f(held)});
      end
    end

    for (int d = 0; d < 4; d++) begin
      apply(1'b0, 2'b01);
      apply(1'b0, 2'(d));
      chk("R2 next", {2'b0, state_q}, (d == 1) ? 4'd2 : {2'b0, 2'(d) + 2'd1});
    end

    apply(1'b0, 2'b01);
    apply(1'b1, 2'b01);
    chk("R1 reset beats loop", {2'b0, state_q}, 4'd0);

    for (int k = 0; k < 6; k++) begin
      logic g;
      apply(1'b0, 2'(k));
      g = gate_open;
      sym = g ? (model - 2'd1) : (model + 2'd1);
      #3;
      chk("R5 latch hold", {3'b0, gate_open}, {3'b0, g});
    end

    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = ($urandom % 64) == 0;
      apply(r, 2'($urandom));
    end

    $display("gate closed in %0d cycles", closed);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule